// File: doc/BRIEF.md
# Pen-Interrupt Scan Trigger

This block sits between the pen-detect line of a resistive touch panel controller and the engine that reads the panel. The pen-detect line is a level. The block turns it into a stream of one-cycle scan-start pulses whose rate is limited. After every pulse it masks the pen line. When the scan engine reports completion, the block holds the line masked for the part of the scan interval that the scan itself did not use. Only then does it look at the pen line again.

A pen-triggered scan also arms a single follow-up timer. The timer length is the scan interval rounded up to whole timer grains, and a grain is 1000 microseconds by default. If the pen line stays quiet until the timer runs out, the block issues one more scan, so the engine gets to see the release. That follow-up scan does not arm a new timer. Any pen activity cancels a pending timer and starts the series again. All timing uses microsecond ticks, which are derived from the system clock by a divider set by a parameter.

Top module: `pen_scan_trigger`

## Requirements
- R1: After reset `irq_masked` is 1 and `scan_start` is 0. With `enable` low the pen line causes no scan and `irq_masked` stays 1.
- R2: When `enable` is high at a clock edge while the block is idle and disabled, `irq_masked` is 0 after that edge.
- R3: The pen line is active high when `PEN_ACTIVE_LOW` is 0, and it passes through two synchronizing flops. When the line is active while the block is unmasked, `scan_start` is high for exactly one cycle, starting at the third edge after the line rose. `irq_masked` is 1 from that same edge.
- R4: No `scan_start` is issued between a scan start and its `scan_done`. The pen line is ignored during the scan and during the rate-limit wait. If the line is still active when the block unmasks, a new scan starts one edge later.
- R5: On `scan_done`, let I be the effective interval and S be `scan_us`. If I > S, `irq_masked` falls (I−S)·TICK_DIV edges after the edge that takes `scan_done`. Otherwise it falls at that edge.
- R6: When the block unmasks after a pen-triggered scan, it arms a follow-up timer. If no pen activity occurs, `scan_start` fires ceil(I/GRAIN_US)·GRAIN_US·TICK_DIV edges after the unmask edge. After the follow-up scan no further timer is armed, and no scan follows without pen activity.
- R7: Pen activity while the follow-up timer runs cancels the timer. The scan it starts arms a fresh timer when the block unmasks again.
- R8: An `interval_us` of 0 selects the interval `DEF_INTERVAL_US`, which is 10000 by default.
- R9: When `enable` is low at an edge, `irq_masked` is 1 after that edge and any follow-up timer is cancelled. Raising `enable` again does not restore the timer. If `enable` is low when `scan_done` arrives, the block stays masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Trigger enable |
| pen_irq | input | 1 | Asynchronous pen-detect level |
| scan_done | input | 1 | One-cycle pulse when a scan has finished |
| interval_us | input | US_W | Scan interval in microseconds, 0 selects the default |
| scan_us | input | US_W | Measured duration of one scan in microseconds |
| scan_start | output | 1 | One-cycle scan request |
| irq_masked | output | 1 | 1 while the pen line is not being watched |

## Verification
The bench builds the block with TICK_DIV=2, GRAIN_US=10 and DEF_INTERVAL_US=25. With these values a full rate-limit wait plus follow-up window lasts only a few hundred cycles. That makes it possible to sweep every interval from 0 to 35 against scan durations below, equal to and above the interval, covering the positive, zero and negative wait cases and every remainder of the grain rounding. The small default also lets the zero-interval path be measured directly.

// File: rtl/pen_scan_trigger.sv
module pen_scan_trigger #(
  parameter int TICK_DIV        = 100,
  parameter int US_W            = 16,
  parameter int GRAIN_US        = 1000,
  parameter int DEF_INTERVAL_US = 10000,
  parameter bit PEN_ACTIVE_LOW  = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            pen_irq,
  input  logic            scan_done,
  input  logic [US_W-1:0] interval_us,
  input  logic [US_W-1:0] scan_us,
  output logic            scan_start,
  output logic            irq_masked
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int GW = (GRAIN_US > 1) ? $clog2(GRAIN_US) : 1;
  localparam int CW = US_W + 1;

  typedef enum logic [1:0] {S_OFF, S_ARMED, S_SCAN, S_WAIT} st_t;

  st_t           state;
  logic [1:0]    sync;
  logic          timer_on, more;
  logic [PW-1:0] pre;
  logic [GW-1:0] gr;
  logic [CW-1:0] cnt;

  wire           pen_s   = sync[1];
  wire [US_W-1:0] ival   = (interval_us == '0) ? US_W'(DEF_INTERVAL_US) : interval_us;
  wire           gap_pos = ival > scan_us;
  wire [CW-1:0]  gap     = {1'b0, ival} - {1'b0, scan_us};
  wire           running = (state == S_WAIT) || timer_on;
  wire           tick    = running && (pre == PW'(TICK_DIV - 1));
  wire           expire  = timer_on && tick && (gr == GW'(GRAIN_US - 1)) &&
                           ({1'b0, ival} <= cnt + CW'(1));
  wire           wait_done = (state == S_WAIT) && tick && (cnt == CW'(1));
  wire           rearm   = enable && (((state == S_SCAN) && scan_done && !gap_pos) || wait_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_OFF;
      sync       <= '0;
      timer_on   <= 1'b0;
      more       <= 1'b0;
      pre        <= '0;
      gr         <= '0;
      cnt        <= '0;
      scan_start <= 1'b0;
      irq_masked <= 1'b1;
    end else begin
      sync       <= {sync[0], pen_irq ^ PEN_ACTIVE_LOW};
      scan_start <= 1'b0;
      pre        <= (running && !tick) ? pre + PW'(1) : '0;
      if (tick) begin
        if (state == S_WAIT) cnt <= cnt - CW'(1);
        else begin
          cnt <= cnt + CW'(1);
          gr  <= (gr == GW'(GRAIN_US - 1)) ? '0 : gr + GW'(1);
        end
      end
      case (state)
        S_OFF: if (enable) begin
          state      <= S_ARMED;
          irq_masked <= 1'b0;
        end
        S_ARMED: begin
          if (!enable) begin
            state      <= S_OFF;
            irq_masked <= 1'b1;
            timer_on   <= 1'b0;
          end else if (pen_s || expire) begin
            state      <= S_SCAN;
            scan_start <= 1'b1;
            irq_masked <= 1'b1;
            timer_on   <= 1'b0;
            more       <= !pen_s;
          end
        end
        S_SCAN: if (scan_done) begin
          if (!enable) state <= S_OFF;
          else if (gap_pos) begin
            state <= S_WAIT;
            cnt   <= gap;
          end
        end
        default: if (!enable) state <= S_OFF;
      endcase
      if (rearm) begin
        state      <= S_ARMED;
        irq_masked <= 1'b0;
        if (!more) begin
          timer_on <= 1'b1;
          cnt      <= '0;
          gr       <= '0;
        end
      end
    end
  end

  logic pend;
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else if (scan_done) pend <= 1'b0;
    else if (scan_start) pend <= 1'b1;
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |=> !scan_start);
  a_r3_masked_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |-> irq_masked);
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |-> !pend);
  a_r9_disable_masks: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> irq_masked);
  a_r2_unmask_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_masked) |-> $past(enable));
endmodule

// File: tb/tb_pen_scan_trigger.sv
module tb_pen_scan_trigger;
  localparam int T = 2, G = 10, DEF = 25, UW = 16;

  logic clk = 0, rst_n = 0, enable = 0, pen = 0, done = 0;
  logic [UW-1:0] ival = 0, sdur = 0;
  logic scan_start, irq_masked;
  int tests = 0, fails = 0;

  pen_scan_trigger #(.TICK_DIV(T), .US_W(UW), .GRAIN_US(G), .DEF_INTERVAL_US(DEF)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pen_irq(pen), .scan_done(done),
    .interval_us(ival), .scan_us(sdur), .scan_start(scan_start), .irq_masked(irq_masked));

  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges_to_start(input int lim, output int n);
    n = 0;
    do begin step(); n++; end while (!scan_start && n <= lim);
  endtask

  task automatic edges_to_unmask(input int lim, output int n);
    n = 0;
    do begin step(); n++; end while (irq_masked && n <= lim);
  endtask

  task automatic quiet(input int cyc, input string req);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin step(); if (scan_start) seen++; end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic pulse_done();
    done = 1; step(); done = 0;
  endtask

  function automatic int eff(input int i); return (i == 0) ? DEF : i; endfunction
  function automatic int win(input int i); return ((eff(i) + G - 1) / G) * G * T; endfunction
  function automatic int unm(input int i, input int s);
    return (eff(i) > s) ? 1 + (eff(i) - s) * T : 1;
  endfunction

  task automatic run_case(input int i, input int s);
    int n, w, u;
    ival = UW'(i); sdur = UW'(s); w = win(i); u = unm(i, s);
    pen = 1; edges_to_start(10, n);
    check(n == 3, "R3 pen to start", n, 3);
    check(irq_masked == 1, "R3 masked at start", irq_masked, 1);
    pen = 0; step(); step(); step();
    pulse_done();
    n = 1; if (irq_masked) begin edges_to_unmask(u + 5, n); n++; end
    check(n == u, (i == 0) ? "R8 default wait" : "R5 wait", n, u);
    edges_to_start(w + 10, n);
    check(n == w, (i == 0) ? "R8 default follow-up" : "R6 follow-up", n, w);
    step(); step(); step();
    pulse_done();
    n = 1; if (irq_masked) begin edges_to_unmask(u + 5, n); n++; end
    check(n == u, "R5 wait after follow-up", n, u);
    quiet(2 * w + 10, "R6 only one follow-up");
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    step(); step(); rst_n = 1; step();
    check(irq_masked == 1, "R1 masked after reset", irq_masked, 1);
    check(scan_start == 0, "R1 no start after reset", scan_start, 0);
    pen = 1; quiet(20, "R1 pen ignored while disabled");
    check(irq_masked == 1, "R1 still masked", irq_masked, 1);
    pen = 0; step(); step(); step();
    enable = 1; step();
    check(irq_masked == 0, "R2 unmask on enable", irq_masked, 0);

    for (int i = 0; i <= 35; i++) begin
      run_case(i, 0);
      run_case(i, i / 2);
      run_case(i, i);
      run_case(i, i + 2);
    end

    // R4: pen held through scan and wait
    ival = 20; sdur = 4;
    pen = 1; edges_to_start(10, n);
    check(n == 3, "R4 first start", n, 3);
    step(); step(); step();
    check(scan_start == 0, "R4 no start while outstanding", scan_start, 0);
    pulse_done();
    edges_to_start(200, n);
    check(n == 1 + 32, "R4 start one edge after unmask", n + 1, 34);
    pen = 0; step(); step(); step();
    pulse_done();
    edges_to_unmask(100, n);
    check(n + 1 == 33, "R5 wait before timer", n + 1, 33);

    // R7: pen during timer restarts the series
    repeat (10) step();
    pen = 1; edges_to_start(10, n);
    check(n == 3, "R7 pen cancels timer", n, 3);
    pen = 0; step(); step(); step();
    pulse_done();
    edges_to_unmask(100, n);
    edges_to_start(200, n);
    check(n == win(20), "R7 fresh follow-up", n, win(20));
    step(); step(); step();
    pulse_done();
    edges_to_unmask(100, n);

    // R9: disable cancels timer
    pen = 1; edges_to_start(10, n);
    pen = 0; step(); step(); step();
    pulse_done();
    edges_to_unmask(100, n);
    repeat (5) step();
    enable = 0; step();
    check(irq_masked == 1, "R9 disable masks", irq_masked, 1);
    pen = 1; quiet(win(20) + 10, "R9 no start while disabled");
    pen = 0; step(); step(); step();
    enable = 1; step();
    check(irq_masked == 0, "R2 re-enable unmasks", irq_masked, 0);
    quiet(2 * win(20), "R9 timer stays cancelled");

    // R9: disable during scan
    pen = 1; edges_to_start(10, n);
    pen = 0; enable = 0; step(); step(); step();
    pulse_done();
    quiet(200, "R9 no start after disabled scan");
    check(irq_masked == 1, "R9 masked after disabled scan", irq_masked, 1);
    enable = 1; step();
    check(irq_masked == 0, "R2 enable after scan", irq_masked, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule